// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit control words on a simple word-addressed bus. It has a read strobe, a write strobe, an address and separate write and read data. A software agent must first write a magic constant to word 0, which unlocks the bank. Until then, writes to the protected part of the map are dropped. Word 0 holds only the resulting lock state (1 = unlocked), never the key itself.

Several kinds of words sit in the map:
- Control words that only ever gain bits through writes, each with a clearing alias at the next word up.
- Two strap words with the same set and clear pairing, plus a protect word two places above each. A nonzero protect word freezes that strap's set path.
- Read-only identity words.
- Two PLL extension words that always report lock on bit 31.
- A random-data word that yields a new value on every read.

Reset values come from parameters and from the strap, revision and protect-key input pins. Read data is registered and appears one cycle after the read strobe.

Word map used throughout:

| Word | Contents |
|------|----------|
| 0 | key flag |
| 1 | revision |
| 2 | secondary revision |
| 3 | chip ID 0 |
| 4 | chip ID 1 |
| 5 | RNG control |
| 6 | random data |
| 8 and 10 | set words; 9 and 11 are their clear aliases |
| 12 and 16 | straps; 13 and 17 clear them; 14 and 18 protect them |
| 20 and 22 | PLL parameters |
| 21 and 23 | PLL extensions |
| all others below 32 | plain storage |

Top module: `scr_regbank`

## Requirements
- R1: A write to word 0 stores 32'h1 when the data equals the KEY parameter (default 32'h1688A8A8) and 32'h0 otherwise; reading word 0 returns that flag.
- R2: While word 0 reads 0, writes to words 1 up to LOCK_LIMIT-1 (default 28) leave every word unchanged; word 0 and words LOCK_LIMIT up to NUM_WORDS-1 stay writable.
- R3: A write to word 8 or 10 ORs the data into the stored value.
- R4: A write to word 9, 11, 13 or 17 clears, in the word one below, each bit that is 1 in the data; the alias words themselves read 0.
- R5: A write to strap word 12 (or 16) ORs in the data only while word 14 (or 18) is zero; its clear alias works whatever the protect word holds.
- R6: Words 1 to 4 and word 6 ignore writes.
- R7: Reads of words 21 and 23 return the stored value with bit 31 forced to 1.
- R8: Each read of word 6 returns a nonzero value different from the previous read of it, whatever bit 0 of word 5 holds.
- R9: Reads of addresses at or above NUM_WORDS (default 32) return 0, and writes there change no word (including the word whose low address bits match).
- R10: At reset, word 0 = {31'b0, prot_key_in}, word 1 = rev_in, word 12 = strap1_in, word 16 = strap2_in, words 2/3/4/8/10 take their parameter values, and all other words are 0.
- R11: rdata changes only in the cycle after a cycle with rd_en high, and holds otherwise.
- R12: A write to any plain word (for example 5, 14, 18, 20, 24) stores the whole data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| strap1_in | input | 32 | Reset value of strap word 12 |
| strap2_in | input | 32 | Reset value of strap word 16 |
| rev_in | input | 32 | Reset value of revision word 1 |
| prot_key_in | input | 1 | Reset value of the unlock flag |

## Verification
The state hardest to reach is a protected strap. Getting there takes an unlock, then a protect write, then a strap set that must bounce while a clear through the alias still lands. The stimulus builds this sequence one write at a time and reads back after each step. Out-of-range writes are aimed at addresses whose low bits alias live set words, so a missing range check shows up as corruption of those words. Random-data reads are issued back to back, with the RNG control bit at both values.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // Word indices; pair spacing is behavioural (alias = +1, protect = +2)
  localparam int unsigned W_KEY      = 0;
  localparam int unsigned W_REV      = 1;
  localparam int unsigned W_REV2     = 2;
  localparam int unsigned W_CHIP0    = 3;
  localparam int unsigned W_CHIP1    = 4;
  localparam int unsigned W_RNG_CTL  = 5;
  localparam int unsigned W_RNG      = 6;
  localparam int unsigned W_SETA     = 8;
  localparam int unsigned W_SETB     = 10;
  localparam int unsigned W_STRAP1   = 12;
  localparam int unsigned W_STRAP2   = 16;
  localparam int unsigned W_PLLA     = 20;
  localparam int unsigned W_PLLA_EXT = 21;
  localparam int unsigned W_PLLB     = 22;
  localparam int unsigned W_PLLB_EXT = 23;
  localparam int unsigned PROT_GAP   = 2;

  typedef enum logic [2:0] {
    K_PLAIN, K_KEY, K_RO, K_SET, K_CLR, K_STRAP
  } kind_e;

  function automatic kind_e word_kind(input int unsigned i);
    kind_e k;
    case (i)
      W_KEY:                                   k = K_KEY;
      W_REV, W_REV2, W_CHIP0, W_CHIP1, W_RNG:  k = K_RO;
      W_SETA, W_SETB:                          k = K_SET;
      W_STRAP1, W_STRAP2:                      k = K_STRAP;
      W_SETA + 1, W_SETB + 1,
      W_STRAP1 + 1, W_STRAP2 + 1:              k = K_CLR;
      default:                                 k = K_PLAIN;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/scr_decode.sv
module scr_decode #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_WORDS  = 32,
  parameter int unsigned LOCK_LIMIT = 28,
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              unlocked,
  output logic              in_range,
  output logic              wr_ok,
  output logic              rd_ext,
  output logic              rd_rng,
  output logic [IDX_W-1:0]  widx
);
  import scr_pkg::*;

  logic [31:0] a32;
  logic        guarded;

  assign a32      = 32'(addr);
  assign widx     = addr[IDX_W-1:0];
  // R9: anything at or above NUM_WORDS is outside the bank
  assign in_range = (a32 < 32'(NUM_WORDS));
  // R2: lock window covers words 1 .. LOCK_LIMIT-1
  assign guarded  = (a32 != 32'd0) && (a32 < 32'(LOCK_LIMIT));
  assign wr_ok    = wr_en && in_range && (!guarded || unlocked);
  // R7 / R8 read-side overrides
  assign rd_ext   = (widx == IDX_W'(W_PLLA_EXT)) || (widx == IDX_W'(W_PLLB_EXT));
  assign rd_rng   = (widx == IDX_W'(W_RNG));

endmodule

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
  parameter logic [31:0] SEED = 32'h1D87_2B41,
  parameter logic [31:0] TAPS = 32'hA300_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [31:0] value
);
  logic [31:0] state_q, state_d;

  // R8: Galois step, advanced once per random-data read
  always_comb begin
    state_d = state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= SEED;
    else if (adv) state_q <= state_d;
  end

  assign value = state_q;

endmodule

// File: rtl/scr_store.sv
module scr_store #(
  parameter int unsigned NUM_WORDS = 32,
  parameter logic [31:0] KEY       = 32'h1688_A8A8,
  parameter logic [31:0] REV2_VAL  = 32'h0000_0A11,
  parameter logic [31:0] CHIP0_VAL = 32'hC0DE_0001,
  parameter logic [31:0] CHIP1_VAL = 32'hC0DE_0002,
  parameter logic [31:0] SETA_RST  = 32'hF0C0_0010,
  parameter logic [31:0] SETB_RST  = 32'h0FF0_0000,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_ok,
  input  logic [IDX_W-1:0]            widx,
  input  logic [31:0]                 wdata,
  input  logic [31:0]                 strap1_in,
  input  logic [31:0]                 strap2_in,
  input  logic [31:0]                 rev_in,
  input  logic                        prot_key_in,
  output logic [NUM_WORDS-1:0][31:0]  regs
);
  import scr_pkg::*;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam kind_e KD = word_kind(i);
    localparam logic [31:0] CRV =
        (i == W_REV2)  ? REV2_VAL  :
        (i == W_CHIP0) ? CHIP0_VAL :
        (i == W_CHIP1) ? CHIP1_VAL :
        (i == W_SETA)  ? SETA_RST  :
        (i == W_SETB)  ? SETB_RST  : 32'h0;

    logic [31:0] q, nxt, rv;
    logic        en;

    // R10: reset value from pins or parameters
    assign rv = (i == W_KEY)    ? {31'b0, prot_key_in} :
                (i == W_REV)    ? rev_in    :
                (i == W_STRAP1) ? strap1_in :
                (i == W_STRAP2) ? strap2_in : CRV;

    if (KD == K_KEY) begin : g_key
      // R1: flag, not the key
      assign en  = wr_ok && (widx == IDX_W'(i));
      assign nxt = {31'b0, (wdata == KEY)};
    end else if (KD == K_SET) begin : g_set
      logic hit_s, hit_c;
      assign hit_s = wr_ok && (widx == IDX_W'(i));
      assign hit_c = wr_ok && (widx == IDX_W'(i + 1));
      assign en    = hit_s || hit_c;
      // R3 set, R4 clear via alias
      assign nxt   = hit_s ? (q | wdata) : (q & ~wdata);
    end else if (KD == K_STRAP) begin : g_strap
      logic hit_s, hit_c;
      // R5: set path frozen by nonzero protect word
      assign hit_s = wr_ok && (widx == IDX_W'(i)) && (regs[i + PROT_GAP] == 32'h0);
      assign hit_c = wr_ok && (widx == IDX_W'(i + 1));
      assign en    = hit_s || hit_c;
      assign nxt   = hit_s ? (q | wdata) : (q & ~wdata);
    end else if (KD == K_PLAIN) begin : g_plain
      // R12
      assign en  = wr_ok && (widx == IDX_W'(i));
      assign nxt = wdata;
    end else begin : g_hold
      // R6 read-only, R4 alias words keep 0
      assign en  = 1'b0;
      assign nxt = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= rv;
      else if (en) q <= nxt;
    end

    assign regs[i] = q;
  end

endmodule

// File: rtl/scr_regbank.sv
module scr_regbank #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_WORDS  = 32,
  parameter int unsigned LOCK_LIMIT = 28,
  parameter logic [31:0] KEY        = 32'h1688_A8A8,
  parameter logic [31:0] REV2_VAL   = 32'h0000_0A11,
  parameter logic [31:0] CHIP0_VAL  = 32'hC0DE_0001,
  parameter logic [31:0] CHIP1_VAL  = 32'hC0DE_0002,
  parameter logic [31:0] SETA_RST   = 32'hF0C0_0010,
  parameter logic [31:0] SETB_RST   = 32'h0FF0_0000,
  parameter logic [31:0] RNG_SEED   = 32'h1D87_2B41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       strap1_in,
  input  logic [31:0]       strap2_in,
  input  logic [31:0]       rev_in,
  input  logic              prot_key_in
);
  import scr_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  logic [NUM_WORDS-1:0][31:0] regs;
  logic                       unlocked, in_range, wr_ok, rd_ext, rd_rng;
  logic [IDX_W-1:0]           widx;
  logic [31:0]                rng_val, rd_nxt, rdata_q;

  assign unlocked = regs[W_KEY][0];

  scr_decode #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .LOCK_LIMIT(LOCK_LIMIT)
  ) u_dec (
    .addr(addr), .wr_en(wr_en), .unlocked(unlocked),
    .in_range(in_range), .wr_ok(wr_ok), .rd_ext(rd_ext),
    .rd_rng(rd_rng), .widx(widx)
  );

  scr_store #(
    .NUM_WORDS(NUM_WORDS), .KEY(KEY), .REV2_VAL(REV2_VAL),
    .CHIP0_VAL(CHIP0_VAL), .CHIP1_VAL(CHIP1_VAL),
    .SETA_RST(SETA_RST), .SETB_RST(SETB_RST)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .widx(widx), .wdata(wdata),
    .strap1_in(strap1_in), .strap2_in(strap2_in), .rev_in(rev_in),
    .prot_key_in(prot_key_in), .regs(regs)
  );

  scr_lfsr #(.SEED(RNG_SEED)) u_rng (
    .clk(clk), .rst_n(rst_n),
    .adv(rd_en && in_range && rd_rng),
    .value(rng_val)
  );

  // Read mux: R9 zero, R7 lock bit, R8 fresh data
  always_comb begin
    if (!in_range)   rd_nxt = 32'h0;
    else if (rd_ext) rd_nxt = regs[widx] | 32'h8000_0000;
    else if (rd_rng) rd_nxt = rng_val;
    else             rd_nxt = regs[widx];
  end

  // R11: registered, updates only on a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= 32'h0;
    else if (rd_en) rdata_q <= rd_nxt;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/scr_regbank_chk.sv
module scr_regbank_chk #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_WORDS  = 32,
  parameter int unsigned LOCK_LIMIT = 28,
  parameter logic [31:0] KEY        = 32'h1688_A8A8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rd_en,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [31:0]                 wdata,
  input logic [31:0]                 rdata,
  input logic                        unlocked,
  input logic [NUM_WORDS-1:0][31:0]  regs
);
  import scr_pkg::*;

  logic [31:0] a32;
  logic        in_win, oob;
  assign a32    = 32'(addr);
  assign oob    = (a32 >= 32'(NUM_WORDS));
  assign in_win = (a32 != 32'd0) && (a32 < 32'(LOCK_LIMIT)) && !oob;

  p_key_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a32 == 32'(W_KEY)) |=> (unlocked == $past(wdata == KEY)));

  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_win && !unlocked) |=> $stable(regs));

  p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlocked && a32 == 32'(W_SETA)) |=>
      (regs[W_SETA] == ($past(regs[W_SETA]) | $past(wdata))));

  p_ro_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a32 == 32'(W_REV)) |=> $stable(regs[W_REV]));

  p_pll_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (a32 == 32'(W_PLLA_EXT) || a32 == 32'(W_PLLB_EXT))) |=> rdata[31]);

  p_rng_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && a32 == 32'(W_RNG)) ##1 (rd_en && a32 == 32'(W_RNG)) |=>
      (rdata != $past(rdata)));

  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && oob) |=> (rdata == 32'h0));

  p_oob_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && oob) |=> $stable(regs));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind scr_regbank scr_regbank_chk #(
  .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .LOCK_LIMIT(LOCK_LIMIT), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .unlocked(unlocked), .regs(regs)
);

// File: tb/tb_scr_regbank.sv
`timescale 1ns/1ps
module tb_scr_regbank;

  localparam int unsigned ADDR_W = 6;
  localparam logic [31:0] KEY    = 32'h1688_A8A8;
  localparam logic [31:0] REV2   = 32'h0000_0A11;
  localparam logic [31:0] CHIP0  = 32'hC0DE_0001;
  localparam logic [31:0] CHIP1  = 32'hC0DE_0002;
  localparam logic [31:0] SETA   = 32'hF0C0_0010;
  localparam logic [31:0] SETB   = 32'h0FF0_0000;
  localparam logic [31:0] STRAP1 = 32'h0000_1200;
  localparam logic [31:0] STRAP2 = 32'h0000_00A5;
  localparam logic [31:0] REV    = 32'h0503_0303;

  logic clk, rst_n, rd_en, wr_en, prot_key_in;
  logic [ADDR_W-1:0] addr;
  logic [31:0] wdata, rdata, strap1_in, strap2_in, rev_in;

  scr_regbank #(
    .ADDR_W(ADDR_W), .NUM_WORDS(32), .LOCK_LIMIT(28), .KEY(KEY),
    .REV2_VAL(REV2), .CHIP0_VAL(CHIP0), .CHIP1_VAL(CHIP1),
    .SETA_RST(SETA), .SETB_RST(SETB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .strap1_in(strap1_in),
    .strap2_in(strap2_in), .rev_in(rev_in), .prot_key_in(prot_key_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // kind 0: exact, 1: differs from previous read and nonzero, 2: nonzero
  typedef struct {
    string       tag;
    int          kind;
    logic [31:0] val;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;
  logic        rd_seen = 1'b0;
  logic [31:0] last_rd = 32'h0;

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag, input int kind = 0);
    exp_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    it.tag = tag; it.kind = kind; it.val = e;
    sb.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: actual=unexpected read expected=none");
      end else begin
        exp_t it;
        it = sb.pop_front();
        n_cmp++;
        if (it.kind == 0) begin
          if (rdata !== it.val) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", it.tag, rdata, it.val);
          end
        end else if (it.kind == 1) begin
          if (rdata === last_rd || rdata === 32'h0) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=new nonzero value (previous %08h)",
                     it.tag, rdata, last_rd);
          end
        end else begin
          if (rdata === 32'h0) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=nonzero", it.tag, rdata);
          end
        end
        last_rd = rdata;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    strap1_in = STRAP1; strap2_in = STRAP2; rev_in = REV; prot_key_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 rdata after reset", rdata, 32'h0);
    rd(0,  32'h0,  "R10 key flag");
    rd(1,  REV,    "R10 revision");
    rd(2,  REV2,   "R10 rev2");
    rd(3,  CHIP0,  "R10 chip0");
    rd(4,  CHIP1,  "R10 chip1");
    rd(8,  SETA,   "R10 set A");
    rd(10, SETB,   "R10 set B");
    rd(12, STRAP1, "R10 strap1");
    rd(16, STRAP2, "R10 strap2");
    rd(5,  32'h0,  "R10 rng ctl");
    rd(21, 32'h8000_0000, "R7 pll A ext at reset");

    // R11 hold while idle, even across a write
    rd(1, REV, "R11 read before hold");
    wr(28, 32'h0000_5555);
    repeat (2) @(negedge clk);
    chk("R11 rdata held", rdata, REV);

    // R2 locked bank
    wr(5, 32'h0000_1234);
    rd(5, 32'h0, "R2 locked write dropped");
    wr(8, 32'hFFFF_FFFF);
    rd(8, SETA, "R2 locked set dropped");
    wr(28, 32'h0000_AAAA);
    rd(28, 32'h0000_AAAA, "R2 word above window writable");

    // R1 key
    wr(0, 32'h0000_DEAD);
    rd(0, 32'h0, "R1 wrong key");
    wr(0, KEY);
    rd(0, 32'h1, "R1 right key");

    // R12 plain words
    wr(5, 32'h0000_00FF);
    rd(5, 32'h0000_00FF, "R12 word 5");
    wr(24, 32'h89AB_CDEF);
    rd(24, 32'h89AB_CDEF, "R12 word 24");
    wr(20, 32'h0000_7777);
    rd(20, 32'h0000_7777, "R12 word 20");

    // R3 / R4 set-clear pairs
    wr(8, 32'h0000_000F);
    rd(8, SETA | 32'h0000_000F, "R3 set A");
    wr(9, 32'hF000_0000);
    rd(8, 32'h00C0_001F, "R4 clear A");
    rd(9, 32'h0, "R4 alias reads zero");
    wr(10, 32'h0000_0001);
    wr(11, 32'h0FF0_0000);
    rd(10, 32'h0000_0001, "R3 R4 set B then clear");

    // R5 straps
    wr(12, 32'h0000_0003);
    rd(12, 32'h0000_1203, "R5 strap1 set unprotected");
    wr(14, 32'h0000_0001);
    rd(14, 32'h0000_0001, "R12 protect word 14");
    wr(12, 32'h00F0_0000);
    rd(12, 32'h0000_1203, "R5 strap1 set blocked");
    wr(13, 32'h0000_0200);
    rd(12, 32'h0000_1003, "R5 strap1 clear while protected");
    wr(18, 32'h0);
    wr(16, 32'h0000_0100);
    rd(16, 32'h0000_01A5, "R5 strap2 set");
    wr(17, 32'h0000_0005);
    rd(16, 32'h0000_01A0, "R5 strap2 clear");

    // R6 read-only
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    rd(1, REV,   "R6 revision");
    rd(2, REV2,  "R6 rev2");
    rd(3, CHIP0, "R6 chip0");
    rd(4, CHIP1, "R6 chip1");

    // R7 PLL ext
    wr(21, 32'h0000_1234);
    rd(21, 32'h8000_1234, "R7 pll A ext");
    wr(23, 32'h7FFF_FFFF);
    rd(23, 32'hFFFF_FFFF, "R7 pll B ext");

    // R8 random data, RNG control bit set then cleared
    wr(6, 32'h0);
    rd(6, 32'h0, "R8 first draw", 2);
    rd(6, 32'h0, "R8 fresh draw ctl=1", 1);
    wr(5, 32'h0000_0000);
    rd(6, 32'h0, "R8 fresh draw ctl=0 a", 1);
    rd(6, 32'h0, "R8 fresh draw ctl=0 b", 1);

    // R9 out of range
    rd(40, 32'h0, "R9 read 40");
    rd(63, 32'h0, "R9 read 63");
    wr(40, 32'hFFFF_FFFF);
    rd(8, 32'h00C0_001F, "R9 write 40 leaves word 8");
    wr(42, 32'hFFFF_FFFF);
    rd(10, 32'h0000_0001, "R9 write 42 leaves word 10");

    // R2 relock
    wr(0, 32'h0);
    rd(0, 32'h0, "R1 relock");
    wr(24, 32'h0);
    rd(24, 32'h89AB_CDEF, "R2 relocked write dropped");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: actual=%0d pending reads expected=0", sb.size());
    end
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule